// File: doc/BRIEF.md
# Inverter Fault Trip and Gate Disable

This block collects every condition that must stop a power inverter and forces the gate drive outputs into their safe state with a latency of a few clock cycles. It has two kinds of fault source.

The first is a set of raw signed ADC codes, one per measurement channel. Each time a new sample set arrives, every code is compared against a common upper limit and a common lower limit. The second is a set of external analog comparator outputs that reach the chip as asynchronous digital inputs. There is an over-limit line and an under-limit line for each comparator pair.

All sources merge into one latched fault bit. While that bit is set, every active-low gate output is driven high, which is the off level. While it is clear, the PWM gate commands pass through after one register stage. An explicit clear re-arms the block, but only in a cycle with no active source. The block also records a code that identifies the first source to trip it.

Top module: `gate_trip_guard`

## Requirements
- R1: During and after reset, `gate_n` is all ones, `fault` is 1 and `cause` is 0. The block stays tripped until it is cleared.
- R2: When `smp_valid` is 1 and a channel's signed code is greater than the signed `lim_hi`, `fault` is 1 after that clock edge. The cause code for channel c above its limit is 1+2c.
- R3: When `smp_valid` is 1 and a channel's signed code is less than the signed `lim_lo`, the block trips in the same way, with cause code 2+2c. A code equal to either limit does not trip.
- R4: While `smp_valid` is 0, the sample codes have no effect on `fault`.
- R5: Each comparator input passes through a two-flop synchronizer, so an input held high is seen at the third clock edge. Comparator pair j has cause code 1+2·N_CH+2j for over-limit and 2+2·N_CH+2j for under-limit.
- R6: Once set, `fault` stays 1 until `clr` is 1 in a cycle with no active source. After that edge `fault` is 0 and `cause` is 0.
- R7: A `clr` in a cycle where any source is active (a limit hit or a synchronized comparator) is ignored, and `fault` stays 1.
- R8: While `fault` is 0, `gate_n` equals `pwm_n` from the previous edge. After a tripping sample edge, `gate_n` is all ones no later than the second edge.
- R9: `cause` holds the code of the source that set `fault` from the cleared state. When several sources trip in the same cycle, the lowest code is kept. Later sources do not change it until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new sample set is present this cycle |
| smp_data | input | N_CH*ADC_W | Raw signed codes, channel c at bits [c*ADC_W +: ADC_W] |
| lim_hi | input | ADC_W | Signed upper limit, shared by all channels |
| lim_lo | input | ADC_W | Signed lower limit, shared by all channels |
| cmp_over | input | N_CMP | Asynchronous over-limit comparator lines |
| cmp_under | input | N_CMP | Asynchronous under-limit comparator lines |
| pwm_n | input | N_GATE | Active-low gate commands from the modulator |
| clr | input | 1 | Re-arm request |
| gate_n | output | N_GATE | Active-low gate drive outputs |
| fault | output | 1 | Latched trip state |
| cause | output | CODE_W | First-fault source code, 0 when none |

## Verification
The assertions check these properties on every cycle:
- A source always trips the block on the next edge.
- The trip state holds unless a clear is accepted.
- A clear that coincides with a source is refused.
- The gates go high one edge after the trip state.
- The gates follow the delayed PWM commands while armed.
- The cause code stays frozen while the block is tripped.

Only the bench scenarios can show the exact cause values for each channel and comparator. The same holds for the inclusive limits and for the three-edge synchronizer delay. The same holds for the lowest-code choice among simultaneous sources and for the end-to-end two-edge gate latency from a sample.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam int CODE_NONE = 0;

  // Source code: channels first (upper, lower), then comparator pairs (over, under).
  function automatic int src_code(input int n_ch, input bit from_cmp,
                                  input int idx, input bit low_side);
    int base;
    base = from_cmp ? 2 * n_ch : 0;
    return 1 + base + 2 * idx + (low_side ? 1 : 0);
  endfunction

  function automatic int code_width(input int n_ch, input int n_cmp);
    return $clog2(2 * (n_ch + n_cmp) + 1);
  endfunction
endpackage

// File: rtl/trip_limit_chk.sv
module trip_limit_chk #(
  parameter int N_CH  = 3,
  parameter int ADC_W = 16
) (
  input  logic                  smp_valid,
  input  logic [N_CH*ADC_W-1:0] smp_data,
  input  logic [ADC_W-1:0]      lim_hi,
  input  logic [ADC_W-1:0]      lim_lo,
  output logic [N_CH-1:0]       over,
  output logic [N_CH-1:0]       under
);
  genvar c;
  generate
    for (c = 0; c < N_CH; c++) begin : g_ch
      logic signed [ADC_W-1:0] code;
      assign code     = smp_data[c*ADC_W +: ADC_W];
      assign over[c]  = smp_valid && (code > $signed(lim_hi));
      assign under[c] = smp_valid && (code < $signed(lim_lo));
    end
  endgenerate
endmodule

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/trip_cause.sv
module trip_cause #(
  parameter int N_CH   = 3,
  parameter int N_CMP  = 3,
  parameter int CODE_W = 4
) (
  input  logic [N_CH-1:0]   over,
  input  logic [N_CH-1:0]   under,
  input  logic [N_CMP-1:0]  cmp_over,
  input  logic [N_CMP-1:0]  cmp_under,
  output logic [CODE_W-1:0] code
);
  import trip_pkg::*;
  // Scan from the highest code down so the lowest active code is left.
  always_comb begin
    code = CODE_W'(CODE_NONE);
    for (int j = N_CMP - 1; j >= 0; j--) begin
      if (cmp_under[j]) code = CODE_W'(src_code(N_CH, 1'b1, j, 1'b1));
      if (cmp_over[j])  code = CODE_W'(src_code(N_CH, 1'b1, j, 1'b0));
    end
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (under[c]) code = CODE_W'(src_code(N_CH, 1'b0, c, 1'b1));
      if (over[c])  code = CODE_W'(src_code(N_CH, 1'b0, c, 1'b0));
    end
  end
endmodule

// File: rtl/trip_core.sv
module trip_core #(
  parameter int N_GATE = 6,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_any,
  input  logic              clr,
  input  logic [CODE_W-1:0] src_code_now,
  input  logic [N_GATE-1:0] pwm_n,
  output logic              tripped_q,
  output logic [CODE_W-1:0] cause_q,
  output logic [N_GATE-1:0] gate_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tripped_q <= 1'b1;
      cause_q   <= '0;
      gate_q    <= '1;
    end else begin
      gate_q <= tripped_q ? '1 : pwm_n;
      if (src_any) begin
        tripped_q <= 1'b1;
        if (!tripped_q) cause_q <= src_code_now;
      end else if (clr) begin
        tripped_q <= 1'b0;
        cause_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/gate_trip_guard.sv
module gate_trip_guard #(
  parameter int N_CH   = 3,
  parameter int ADC_W  = 16,
  parameter int N_CMP  = 3,
  parameter int N_GATE = 6,
  localparam int CODE_W = trip_pkg::code_width(N_CH, N_CMP)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_valid,
  input  logic [N_CH*ADC_W-1:0] smp_data,
  input  logic [ADC_W-1:0]      lim_hi,
  input  logic [ADC_W-1:0]      lim_lo,
  input  logic [N_CMP-1:0]      cmp_over,
  input  logic [N_CMP-1:0]      cmp_under,
  input  logic [N_GATE-1:0]     pwm_n,
  input  logic                  clr,
  output logic [N_GATE-1:0]     gate_n,
  output logic                  fault,
  output logic [CODE_W-1:0]     cause
);
  // Named internal events
  logic [N_CH-1:0]   lim_over, lim_under;
  logic [N_CMP-1:0]  cmp_over_s, cmp_under_s;
  logic [CODE_W-1:0] code_now;
  logic              src_any;
  logic              clr_ok;

  trip_limit_chk #(.N_CH(N_CH), .ADC_W(ADC_W)) u_lim (
    .smp_valid(smp_valid), .smp_data(smp_data), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .over(lim_over), .under(lim_under)
  );

  trip_sync #(.W(2*N_CMP)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cmp_under, cmp_over}), .q({cmp_under_s, cmp_over_s})
  );

  trip_cause #(.N_CH(N_CH), .N_CMP(N_CMP), .CODE_W(CODE_W)) u_cause (
    .over(lim_over), .under(lim_under),
    .cmp_over(cmp_over_s), .cmp_under(cmp_under_s), .code(code_now)
  );

  assign src_any = (|lim_over) | (|lim_under) | (|cmp_over_s) | (|cmp_under_s);
  assign clr_ok  = clr && !src_any;

  trip_core #(.N_GATE(N_GATE), .CODE_W(CODE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .src_any(src_any), .clr(clr),
    .src_code_now(code_now), .pwm_n(pwm_n),
    .tripped_q(fault), .cause_q(cause), .gate_q(gate_n)
  );
endmodule

// File: rtl/gate_trip_guard_chk.sv
module gate_trip_guard_chk #(
  parameter int N_CH   = 3,
  parameter int N_CMP  = 3,
  parameter int N_GATE = 6,
  localparam int CODE_W = trip_pkg::code_width(N_CH, N_CMP)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_any,
  input logic              clr,
  input logic              clr_ok,
  input logic              fault,
  input logic [N_GATE-1:0] pwm_n,
  input logic [N_GATE-1:0] gate_n,
  input logic [CODE_W-1:0] cause
);
  AST_SRC_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    src_any |=> fault); // R2
  AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !clr_ok |=> fault); // R6
  AST_CLR_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    src_any && clr |=> fault); // R7
  AST_SAFE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> gate_n == '1); // R8
  AST_GATE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |=> gate_n == $past(pwm_n)); // R8
  AST_CAUSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !clr |=> $stable(cause)); // R9
endmodule

bind gate_trip_guard gate_trip_guard_chk #(.N_CH(N_CH), .N_CMP(N_CMP), .N_GATE(N_GATE)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_any(src_any), .clr(clr), .clr_ok(clr_ok),
  .fault(fault), .pwm_n(pwm_n), .gate_n(gate_n), .cause(cause)
);

// File: tb/gate_trip_guard_tb_top.sv
`timescale 1ns/1ps
module gate_trip_guard_tb_top;
  localparam int NC = 3, W = 16, NP = 3, NG = 6, CW = 4;
  logic clk = 0, rst_n = 0;
  logic smp_valid = 0;
  logic [NC*W-1:0] smp_data = '0;
  logic [W-1:0] lim_hi = 16'sd1000, lim_lo = -16'sd1000;
  logic [NP-1:0] cmp_over = '0, cmp_under = '0;
  logic [NG-1:0] pwm_n = '1;
  logic clr = 0;
  logic [NG-1:0] gate_n;
  logic fault;
  logic [CW-1:0] cause;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gate_trip_guard #(.N_CH(NC), .ADC_W(W), .N_CMP(NP), .N_GATE(NG)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .cmp_over(cmp_over), .cmp_under(cmp_under),
    .pwm_n(pwm_n), .clr(clr), .gate_n(gate_n), .fault(fault), .cause(cause)
  );

  // Expected cause: lowest-numbered active source per the requirement encoding
  function automatic int ref_code(bit v, logic [NC*W-1:0] d, logic [W-1:0] hi, logic [W-1:0] lo,
                                  logic [NP-1:0] co, logic [NP-1:0] cu);
    for (int c = 0; c < NC; c++) begin
      logic signed [W-1:0] x;
      x = d[c*W +: W];
      if (v && x > $signed(hi)) return 1 + 2*c;
      if (v && x < $signed(lo)) return 2 + 2*c;
    end
    for (int j = 0; j < NP; j++) begin
      if (co[j]) return 1 + 2*NC + 2*j;
      if (cu[j]) return 2 + 2*NC + 2*j;
    end
    return 0;
  endfunction

  // Reference state, advanced from the requirements at each edge
  logic [NP-1:0] m_co1, m_co2, m_cu1, m_cu2;
  logic m_trip;
  int m_cause;
  logic [NG-1:0] m_gate;
  always @(posedge clk) begin : model
    int k;
    if (!rst_n) begin
      m_trip <= 1; m_cause <= 0; m_gate <= '1;
      m_co1 <= '0; m_co2 <= '0; m_cu1 <= '0; m_cu2 <= '0;
    end else begin
      k = ref_code(smp_valid, smp_data, lim_hi, lim_lo, m_co2, m_cu2);
      m_gate <= m_trip ? '1 : pwm_n;
      if (k != 0) begin
        m_trip <= 1;
        if (!m_trip) m_cause <= k;
      end else if (clr) begin
        m_trip <= 0; m_cause <= 0;
      end
      m_co1 <= cmp_over; m_co2 <= m_co1; m_cu1 <= cmp_under; m_cu2 <= m_cu1;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic set_ch(int c, int v);
    smp_data[c*W +: W] = W'(v);
  endtask

  task automatic quiet();
    smp_valid = 0; smp_data = '0; cmp_over = '0; cmp_under = '0; clr = 0;
  endtask

  task automatic rearm();
    quiet(); clr = 1; step(); clr = 0;
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_0042));
    step(3);
    // R1: reset state
    chk("R1 gate", gate_n, 6'h3f); chk("R1 fault", fault, 1); chk("R1 cause", cause, 0);
    rst_n = 1; step(2);
    chk("R1 stays tripped", fault, 1); chk("R1 gate held", gate_n, 6'h3f);

    // R6: clear with no source re-arms; R8: pass-through
    rearm();
    chk("R6 cleared", fault, 0);
    pwm_n = 6'b101010; step();
    chk("R8 follow", gate_n, 6'b101010);

    // R2 + R8: upper hit on channel 1, two-edge gate latency
    pwm_n = 6'b010101; smp_valid = 1; set_ch(1, 1001); step(); quiet();
    chk("R2 fault", fault, 1); chk("R2 cause", cause, 3);
    chk("R8 edge1", gate_n, 6'b010101);
    step(); chk("R8 edge2 safe", gate_n, 6'h3f);

    // R3: values equal to the limits do not trip
    rearm();
    smp_valid = 1; set_ch(0, 1000); set_ch(2, -1000); step(); quiet();
    chk("R3 inclusive", fault, 0);
    smp_valid = 1; set_ch(2, -1001); step(); quiet();
    chk("R3 lower cause", cause, 6);

    // R4: out-of-range codes without valid
    rearm();
    smp_valid = 0; set_ch(0, 30000); set_ch(1, -30000); step(3); quiet();
    chk("R4 ignored", fault, 0);

    // R5: comparator under[1] through the synchronizer
    cmp_under[1] = 1; step();
    chk("R5 edge1", fault, 0); step();
    chk("R5 edge2", fault, 0); step();
    chk("R5 edge3", fault, 1); chk("R5 cause", cause, 10);

    // R7: clear refused while comparator still active
    clr = 1; step(); clr = 0;
    chk("R7 refused", fault, 1);
    cmp_under = '0; step(2); rearm();
    chk("R6 rearm after drop", fault, 0);

    // R7: clear coinciding with a sample hit
    smp_valid = 1; set_ch(0, 2000); clr = 1; step(); quiet();
    chk("R7 same cycle", fault, 1);

    // R9: simultaneous sources keep lowest code, later ones ignored
    rearm();
    smp_valid = 1; set_ch(2, 5000); set_ch(0, -5000); step(); quiet();
    chk("R9 lowest", cause, 2);
    smp_valid = 1; set_ch(1, 5000); step(); quiet();
    chk("R9 kept", cause, 2);
    cmp_over[0] = 1; step(4); cmp_over = '0;
    chk("R9 kept cmp", cause, 2);
    step(3);

    // Random phase against the reference model
    for (int i = 0; i < 3000; i++) begin
      smp_valid = ($urandom_range(0, 1) == 1);
      for (int c = 0; c < NC; c++) set_ch(c, int'($urandom_range(0, 2200)) - 1100);
      cmp_over  = ($urandom_range(0, 29) == 0) ? NP'($urandom) : '0;
      cmp_under = ($urandom_range(0, 29) == 0) ? NP'($urandom) : '0;
      clr = ($urandom_range(0, 2) == 0);
      pwm_n = NG'($urandom);
      step();
      chk("R8 rand gate", gate_n, m_gate);
      chk("R6 rand fault", fault, m_trip);
      chk("R9 rand cause", cause, m_cause);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule